// File: doc/BRIEF.md
# Lane Event Counter

This block counts one chosen link event on one chosen lane of a multi-lane serial link controller. The protocol logic outside it supplies a flat vector of single-cycle event strobes. Each lane has a set of groups, and each group has a fixed number of events. Software picks a group, an event inside that group and a lane through a 32-bit control word. It then reads the running count from a 32-bit data word.

Starting, stopping and clearing are coded command fields inside the control word, not single bits. Each command acts once, when the control word is written. Changing the selection leaves the accumulated count in place, so software clears the counter explicitly when it moves to a new event.

The register port is a simple write strobe with an address and write data. Read data is combinational from the address. The control word is at byte offset 0x8 and the data word at offset 0xC.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset, the control word (0x8) and the data word (0xC) both read 0, and counting is disabled.
- R2: A write to 0x8 stores three selection fields: group in bits 27:24, event in bits 23:16 and lane in bits 11:8. A read of 0x8 returns these fields in the same positions, the status in bit 7, and zero in every other bit, including the command bits 4:0.
- R3: Enable command field bits 4:2 of a control write: code 3 enables counting, code 1 disables it, and any other code leaves the enable state unchanged. Bit 7 of the control word reads 1 exactly while counting is enabled.
- R4: While counting is enabled, every cycle in which the selected strobe is high adds one to the counter. The selected strobe is at flat index (lane*NUM_GROUPS + group)*EVTS_PER_GROUP + event. The new value reads at 0xC from the next cycle on. An enable-state change takes effect in the cycle after the control write.
- R5: Strobes of unselected lanes, groups or events never change the counter.
- R6: Clear command field bits 1:0 of a control write: code 1 sets the counter to 0. Codes 0, 2 and 3 leave the counter unchanged.
- R7: When a clear command and a counted strobe fall in the same cycle, the counter becomes 0.
- R8: Writing a new selection does not clear the counter; counting continues from the held value on the new source.
- R9: The counter is CNT_W bits wide (32 by default) and wraps from all ones to 0.
- R10: A selection whose lane, group or event is at or above NUM_LANES, NUM_GROUPS or EVTS_PER_GROUP counts nothing, even when every strobe is high.
- R11: Writes to the data word are ignored. Reads of any offset other than 0x8 and 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_LANES*NUM_GROUPS*EVTS_PER_GROUP | Per-lane event strobes, lane-major then group then event |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |

## Verification
The bench writes commands in the same cycle as a strobe of the selected event. This catches a design that applies an enable or disable immediately rather than one cycle later, and a design that lets the increment beat the clear. It issues the undefined enable and clear codes: a decoder that tests only one bit of a field would toggle the enable state or wipe the counter. It also moves the selection between measurements and drives every strobe while the selection is out of range. A design that clears on reselection, or indexes past the valid strobes, would show a wrong count. A narrow second instance is driven to all ones and one step further to expose a counter that saturates instead of wrapping.

// File: rtl/lane_evt_counter_pkg.sv
package lane_evt_counter_pkg;

  localparam int unsigned CTRL_OFF = 32'h08;
  localparam int unsigned DATA_OFF = 32'h0C;

  localparam logic [2:0] EN_CODE_ON  = 3'd3;
  localparam logic [2:0] EN_CODE_OFF = 3'd1;
  localparam logic [1:0] CLR_CODE    = 2'd1;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } sel_t;

  typedef struct packed {
    sel_t sel;
    logic en_on;
    logic en_off;
    logic clr;
  } cmd_t;

endpackage

// File: rtl/lec_cmd_decode.sv
module lec_cmd_decode
  import lane_evt_counter_pkg::*;
(
  input  logic [31:0] wdata_i,
  output cmd_t        cmd_o
);

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:28], wdata_i[15:12], wdata_i[7:5]};

  always_comb begin
    cmd_o.sel.grp  = wdata_i[27:24];
    cmd_o.sel.evt  = wdata_i[23:16];
    cmd_o.sel.lane = wdata_i[11:8];
    cmd_o.en_on    = (wdata_i[4:2] == EN_CODE_ON);
    cmd_o.en_off   = (wdata_i[4:2] == EN_CODE_OFF);
    cmd_o.clr      = (wdata_i[1:0] == CLR_CODE);
  end

endmodule

// File: rtl/lec_evt_select.sv
module lec_evt_select
  import lane_evt_counter_pkg::*;
#(
  parameter int unsigned NUM_LANES      = 4,
  parameter int unsigned NUM_GROUPS     = 8,
  parameter int unsigned EVTS_PER_GROUP = 20,
  localparam int unsigned PER_LANE      = NUM_GROUPS * EVTS_PER_GROUP,
  localparam int unsigned NUM_STROBES   = NUM_LANES * PER_LANE
) (
  input  logic [NUM_STROBES-1:0] evt_i,
  input  sel_t                   sel_i,
  output logic                   hit_o
);

  localparam int unsigned LIDX_W = (PER_LANE > 1) ? $clog2(PER_LANE) : 1;
  localparam int unsigned LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic              ev_ok;
  logic              lane_ok;
  logic [LIDX_W-1:0] ev_idx;
  logic [NUM_LANES-1:0] lane_hit;

  always_comb begin
    int unsigned flat;
    ev_ok   = (32'(sel_i.grp) < NUM_GROUPS) && (32'(sel_i.evt) < EVTS_PER_GROUP);
    lane_ok = (32'(sel_i.lane) < NUM_LANES);
    flat    = 32'(sel_i.grp) * EVTS_PER_GROUP + 32'(sel_i.evt);
    ev_idx  = LIDX_W'(flat);
  end

  // one in-lane mux per lane, then pick the lane
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [PER_LANE-1:0] lane_vec;
    assign lane_vec    = evt_i[l*PER_LANE +: PER_LANE];
    assign lane_hit[l] = ev_ok & lane_vec[ev_idx];
  end

  assign hit_o = lane_ok & lane_hit[LANE_W'(sel_i.lane)];

endmodule

// File: rtl/lec_counter.sv
module lec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;   // clear beats a same-cycle increment
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
  import lane_evt_counter_pkg::*;
#(
  parameter int unsigned NUM_LANES      = 4,
  parameter int unsigned NUM_GROUPS     = 8,
  parameter int unsigned EVTS_PER_GROUP = 20,
  parameter int unsigned CNT_W          = 32,
  parameter int unsigned ADDR_W         = 8,
  localparam int unsigned NUM_STROBES   = NUM_LANES * NUM_GROUPS * EVTS_PER_GROUP
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_STROBES-1:0] evt_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o
);

  cmd_t             cmd;
  sel_t             sel_q;
  logic             en_q;
  logic             ctrl_wr;
  logic             hit;
  logic [CNT_W-1:0] cnt_w;

  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_OFF));

  lec_cmd_decode i_decode (
    .wdata_i (reg_wdata_i),
    .cmd_o   (cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (ctrl_wr) begin
      sel_q <= cmd.sel;
      if (cmd.en_on)       en_q <= 1'b1;
      else if (cmd.en_off) en_q <= 1'b0;
    end
  end

  lec_evt_select #(
    .NUM_LANES      (NUM_LANES),
    .NUM_GROUPS     (NUM_GROUPS),
    .EVTS_PER_GROUP (EVTS_PER_GROUP)
  ) i_select (
    .evt_i (evt_i),
    .sel_i (sel_q),
    .hit_o (hit)
  );

  lec_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr && cmd.clr),
    .inc_i  (en_q && hit),
    .cnt_o  (cnt_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(CTRL_OFF))
      reg_rdata_o = {4'h0, sel_q.grp, sel_q.evt, 4'h0, sel_q.lane, en_q, 7'h00};
    else if (reg_addr_i == ADDR_W'(DATA_OFF))
      reg_rdata_o = 32'(cnt_w);
  end

endmodule

// File: rtl/lec_checker.sv
module lec_checker
  import lane_evt_counter_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [4:0]       wdata_cmd_i,
  input logic [7:0]       rdata_lo_i,
  input logic             en_i,
  input logic [CNT_W-1:0] cnt_i
);

  logic ctrl_wr, clr_cmd, on_cmd, off_cmd;
  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_OFF));
  assign clr_cmd = ctrl_wr && (wdata_cmd_i[1:0] == CLR_CODE);
  assign on_cmd  = ctrl_wr && (wdata_cmd_i[4:2] == EN_CODE_ON);
  assign off_cmd = ctrl_wr && (wdata_cmd_i[4:2] == EN_CODE_OFF);

  p_rd_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(CTRL_OFF)) |-> (rdata_lo_i == {en_i, 7'h00}));

  p_en_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_cmd |=> en_i);

  p_en_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_cmd |=> !en_i);

  p_hold_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_cmd) |=> $stable(cnt_i));

  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_cmd |=> ((cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + CNT_W'(1))));

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> (cnt_i == '0));

endmodule

bind lane_evt_counter lec_checker #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) i_lec_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wdata_cmd_i (reg_wdata_i[4:0]),
  .rdata_lo_i  (reg_rdata_o[7:0]),
  .en_i        (en_q),
  .cnt_i       (cnt_w)
);

// File: tb/test_lane_evt_counter.sv
module test_lane_evt_counter;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int NG = 8;
  localparam int NE = 20;
  localparam int NS = NL * NG * NE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] evt = '0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    bit          narrow;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_evt_counter i_lane_evt_counter (
    .clk_i (clk), .rst_ni (rst_n), .evt_i (evt),
    .reg_we_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata)
  );

  lane_evt_counter #(.CNT_W(8)) i_lane_evt_counter_narrow (
    .clk_i (clk), .rst_ni (rst_n), .evt_i (evt),
    .reg_we_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata_n)
  );

  function automatic int flat(int lane, int grp, int ev);
    return (lane * NG + grp) * NE + ev;
  endfunction

  function automatic logic [NS-1:0] one(int idx);
    logic [NS-1:0] v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] mk(int grp, int ev, int lane, int en, int clr);
    return {4'h0, 4'(grp), 8'(ev), 4'h0, 4'(lane), 3'b000, 3'(en), 2'(clr)};
  endfunction

  function automatic logic [31:0] rb(int grp, int ev, int lane, bit st);
    return {4'h0, 4'(grp), 8'(ev), 4'h0, 4'(lane), st, 7'h00};
  endfunction

  task automatic step(logic w, logic [7:0] a, logic [31:0] d, logic [NS-1:0] e);
    @(negedge clk);
    we = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic wr(logic [31:0] d, logic [NS-1:0] e = '0);
    step(1'b1, 8'h08, d, e);
  endtask

  task automatic pulse(logic [NS-1:0] e, int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, '0, e);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag, bit narrow = 1'b0);
    item_t it;
    step(1'b0, a, '0, '0);
    it.exp = exp; it.narrow = narrow; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compares at a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        act = it.narrow ? rdata_n : rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] s, nb;
    s  = one(flat(1, 2, 5));
    nb = one(flat(0, 2, 5)) | one(flat(1, 2, 6)) | one(flat(1, 3, 5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(8'h08, 32'h0, "R1 ctrl after reset");
    rd(8'h0C, 32'h0, "R1 data after reset");

    wr(mk(2, 5, 1, 3, 1));
    rd(8'h08, rb(2, 5, 1, 1'b1), "R2 R3 readback and enable");
    pulse(s, 5);
    rd(8'h0C, 32'd5, "R4 five strobes");
    pulse(one(flat(0, 2, 5)), 4);
    pulse(one(flat(1, 2, 6)), 4);
    pulse(one(flat(1, 3, 5)), 4);
    rd(8'h0C, 32'd5, "R5 neighbours ignored");
    pulse(s | nb, 3);
    rd(8'h0C, 32'd8, "R4 R5 mixed strobes");

    wr(mk(2, 5, 1, 2, 0));
    rd(8'h08, rb(2, 5, 1, 1'b1), "R3 undefined enable code keeps state");
    rd(8'h0C, 32'd8, "R3 undefined enable code keeps count");

    wr(mk(2, 5, 1, 1, 0), s);   // strobe in disable cycle still counts
    pulse(s, 3);
    rd(8'h0C, 32'd9, "R4 disable one cycle late");
    rd(8'h08, rb(2, 5, 1, 1'b0), "R3 status off");

    wr(mk(2, 5, 1, 3, 0), s);   // strobe in enable cycle not counted
    rd(8'h0C, 32'd9, "R4 enable one cycle late");
    pulse(s, 2);
    rd(8'h0C, 32'd11, "R4 counting resumed");

    wr(mk(2, 5, 1, 0, 2));
    rd(8'h0C, 32'd11, "R6 clear code 2 ignored");
    wr(mk(2, 5, 1, 0, 3));
    rd(8'h0C, 32'd11, "R6 clear code 3 ignored");

    wr(mk(2, 5, 1, 0, 1), s);
    rd(8'h0C, 32'd0, "R7 clear beats strobe");
    rd(8'h08, rb(2, 5, 1, 1'b1), "R6 clear keeps enable");
    pulse(s, 1);
    rd(8'h0C, 32'd1, "R6 count after clear");

    wr(mk(7, 8'h13, 3, 0, 0));
    rd(8'h0C, 32'd1, "R8 reselect keeps count");
    rd(8'h08, rb(7, 8'h13, 3, 1'b1), "R2 new selection");
    pulse(one(flat(3, 7, 19)), 2);
    rd(8'h0C, 32'd3, "R8 counts new source");
    pulse(s, 2);
    rd(8'h0C, 32'd3, "R5 old source ignored");

    wr(mk(7, 8'h13, 4, 0, 0));
    pulse('1, 3);
    rd(8'h0C, 32'd3, "R10 lane out of range");
    wr(mk(8, 0, 0, 0, 0));
    pulse('1, 3);
    rd(8'h0C, 32'd3, "R10 group out of range");
    wr(mk(0, 20, 0, 0, 0));
    pulse('1, 3);
    rd(8'h0C, 32'd3, "R10 event out of range");

    step(1'b1, 8'h0C, 32'hDEADBEEF, '0);
    rd(8'h0C, 32'd3, "R11 data write ignored");
    rd(8'h10, 32'h0, "R11 unmapped offset 0x10");
    rd(8'h04, 32'h0, "R11 unmapped offset 0x04");

    wr(mk(0, 0, 0, 3, 1));
    pulse(one(flat(0, 0, 0)), 255);
    rd(8'h0C, 32'hFF, "R9 narrow at all ones", 1'b1);
    rd(8'h0C, 32'hFF, "R9 wide at 255");
    pulse(one(flat(0, 0, 0)), 1);
    rd(8'h0C, 32'h0, "R9 narrow wraps to zero", 1'b1);
    rd(8'h0C, 32'h100, "R9 wide carries on");

    step(1'b0, 8'h00, '0, '0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule